// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the intermediate-frequency signal of a tuner. It counts rising edges of the IF input during a gate window that is timed from the reference clock. A control level starts a measurement. The block then waits a fixed 3.5 ms settling interval, opens a gate of 4, 8, 16 or 32 ms, and freezes the edge count when the gate closes. The count is held on a plain output for a serial readout engine, together with a done flag.

The block also drives a single shared open-drain status line. A 3-bit selector picks what that line reports: nothing (open), loss of PLL lock, end of measurement, signal-detect, or stereo. Lock loss comes from a small detector that passes the phase-error level straight through or stretches it by 1.5 ms. While chip-enable is high, the line is always released, because the serial port owns it then.

All timing is counted in half-millisecond units of `HALF_MS_CYC` clock cycles. There is no handshake at the edges of the block. The count is meant to be read once `done_o` is high and stays valid until `start_i` drops.

Top module: `ifc_counter_top`

## Requirements
- R1: After reset, `count_o` is 0, `done_o` is 0, `unlock_o` is 0 and `status_low_o` is 0 (line open).
- R2: In any state, one cycle after `start_i` is sampled low, `count_o` is 0 and `done_o` is 0, and the block stays idle.
- R3: After `start_i` rises, a wait of 7 half-ms units passes in which no edge is counted.
- R4: `gate_sel_i` is sampled when a measurement starts. The values 00, 01, 10 and 11 select gates of 8, 16, 32 and 64 half-ms units. `done_o` rises (1 + wait + gate) clock edges after the first edge that sees `start_i` high.
- R5: Each rising edge of `if_i` that has passed the two-flop synchronizer adds one to the count while the gate is open. Once `done_o` is high, `count_o` is frozen and `done_o` stays high until `start_i` drops.
- R6: The count saturates at all ones and never wraps.
- R7: `status_sel_i` encoding: 000, 011, 100 and 111 leave the line open. 001 pulls it low on unlock. 010 selects end-of-count. 101 pulls it low while `sd_on_i` is high. 110 pulls it low while `stereo_i` is high. `status_low_o` = 1 means the line is pulled low.
- R8: In end-of-count mode the line is open while idle, waiting or gating, and it is pulled low once the measurement is done.
- R9: While `ce_i` is high, `status_low_o` is 0 in every mode.
- R10: `ul_mode_i` encoding: 00 holds `unlock_o` at 0. 01 makes `unlock_o` follow `phase_err_i` one cycle later. 1x sets `unlock_o` in the cycle after `phase_err_i` is seen and holds it for 3 more half-ms units after the last cycle in which the error was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level: 1 runs a measurement, 0 clears and idles |
| gate_sel_i | input | 2 | Gate length select |
| if_i | input | 1 | Asynchronous IF input |
| ul_mode_i | input | 2 | Unlock detector mode |
| phase_err_i | input | 1 | Phase-error level from the phase comparator |
| status_sel_i | input | 3 | Status line source select |
| ce_i | input | 1 | Chip-enable; high forces the line open |
| sd_on_i | input | 1 | Station-detect indication |
| stereo_i | input | 1 | Stereo indication |
| count_o | output | CNT_W | Edge count, frozen when done |
| done_o | output | 1 | Measurement complete |
| unlock_o | output | 1 | Lock-loss indication |
| status_low_o | output | 1 | 1 pulls the shared status line low |

## Verification
The bench builds the block with `CNT_W` = 6 and `HALF_MS_CYC` = 4. With these values the wait is 28 cycles and the gates run from 32 to 256 cycles, so all four gate lengths can be timed in a few hundred cycles each. The 6-bit count also saturates at 63 when the IF toggles every cycle on the longest gate. The stretch window shrinks to 12 cycles, so its full length can be counted edge by edge.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_DONE = 2'd3
  } ifc_state_e;

  typedef enum logic [2:0] {
    SEL_OPEN_A = 3'b000,
    SEL_UNLOCK = 3'b001,
    SEL_EOC    = 3'b010,
    SEL_OPEN_B = 3'b011,
    SEL_OPEN_C = 3'b100,
    SEL_SD     = 3'b101,
    SEL_STEREO = 3'b110,
    SEL_OPEN_D = 3'b111
  } stat_sel_e;

  localparam int WAIT_UNITS    = 7;  // 3.5 ms in half-ms units
  localparam int GATE_UNITS    = 8;  // shortest gate, 4 ms
  localparam int STRETCH_UNITS = 3;  // 1.5 ms
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], sig_i};
  end

  // last synchronized stage high, history stage low
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/ifc_gate_ctrl.sv
module ifc_gate_ctrl
  import ifc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int HALF_MS_CYC = 2250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  localparam int WAIT_CYC  = WAIT_UNITS * HALF_MS_CYC;
  localparam int GATE_BASE = GATE_UNITS * HALF_MS_CYC;
  localparam int MAX_GATE  = GATE_BASE * 8;
  localparam int CYC_W     = $clog2(MAX_GATE + 1);

  ifc_state_e        state_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [CYC_W-1:0]  glen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_full;

  assign cnt_full = (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      glen_q  <= '0;
      cnt_q   <= '0;
    end else if (!start_i) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_WAIT;
          cyc_q   <= '0;
          cnt_q   <= '0;
          glen_q  <= CYC_W'(GATE_BASE) << gate_sel_i;
        end
        ST_WAIT: begin
          if (cyc_q == CYC_W'(WAIT_CYC - 1)) begin
            state_q <= ST_GATE;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_GATE: begin
          if (rise_i && !cnt_full) cnt_q <= cnt_q + 1'b1;
          if (cyc_q == glen_q - CYC_W'(1)) begin
            state_q <= ST_DONE;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign count_o = cnt_q;
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/ifc_unlock_det.sv
module ifc_unlock_det
  import ifc_pkg::*;
#(
  parameter int HALF_MS_CYC = 2250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       err_i,
  output logic       unlock_o
);
  localparam int STRETCH = STRETCH_UNITS * HALF_MS_CYC;
  localparam int SW      = $clog2(STRETCH + 1);

  logic [SW-1:0] hold_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      unique case (mode_i)
        2'b00: begin
          hold_q <= '0;
          flag_q <= 1'b0;
        end
        2'b01: begin
          hold_q <= '0;
          flag_q <= err_i;
        end
        default: begin
          if (err_i) begin
            hold_q <= SW'(STRETCH);
            flag_q <= 1'b1;
          end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            flag_q <= 1'b1;
          end else begin
            flag_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign unlock_o = flag_q;
endmodule

// File: rtl/ifc_status_mux.sv
module ifc_status_mux
  import ifc_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       ce_i,
  input  logic       unlock_i,
  input  logic       done_i,
  input  logic       sd_i,
  input  logic       stereo_i,
  output logic       low_o
);
  logic pick;

  always_comb begin
    unique case (stat_sel_e'(sel_i))
      SEL_UNLOCK: pick = unlock_i;
      SEL_EOC:    pick = done_i;
      SEL_SD:     pick = sd_i;
      SEL_STEREO: pick = stereo_i;
      default:    pick = 1'b0;
    endcase
  end

  assign low_o = pick & ~ce_i;
endmodule

// File: rtl/ifc_counter_top.sv
module ifc_counter_top #(
  parameter int CNT_W       = 20,
  parameter int HALF_MS_CYC = 2250,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             if_i,
  input  logic [1:0]       ul_mode_i,
  input  logic             phase_err_i,
  input  logic [2:0]       status_sel_i,
  input  logic             ce_i,
  input  logic             sd_on_i,
  input  logic             stereo_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             unlock_o,
  output logic             status_low_o
);
  logic if_rise;

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (if_i),
    .rise_o (if_rise)
  );

  ifc_gate_ctrl #(.CNT_W(CNT_W), .HALF_MS_CYC(HALF_MS_CYC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .gate_sel_i (gate_sel_i),
    .rise_i     (if_rise),
    .count_o    (count_o),
    .done_o     (done_o)
  );

  ifc_unlock_det #(.HALF_MS_CYC(HALF_MS_CYC)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (ul_mode_i),
    .err_i    (phase_err_i),
    .unlock_o (unlock_o)
  );

  ifc_status_mux u_mux (
    .sel_i    (status_sel_i),
    .ce_i     (ce_i),
    .unlock_i (unlock_o),
    .done_i   (done_o),
    .sd_i     (sd_on_i),
    .stereo_i (stereo_i),
    .low_o    (status_low_o)
  );
endmodule

// File: rtl/ifc_counter_chk.sv
module ifc_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ce_i,
  input logic [2:0]       status_sel_i,
  input logic [1:0]       ul_mode_i,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             unlock_o,
  input logic             status_low_o
);
  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (count_o == '0 && !done_o));

  // R5
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> $stable(count_o));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_i) |-> (count_o >= $past(count_o)));

  // R8
  eoc_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_sel_i == 3'b010 && !done_o) |-> !status_low_o);

  // R9
  ce_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_i |-> !status_low_o);

  // R10
  unlock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ul_mode_i) == 2'b00) |-> !unlock_o);
endmodule

bind ifc_counter_top ifc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ce_i         (ce_i),
  .status_sel_i (status_sel_i),
  .ul_mode_i    (ul_mode_i),
  .count_o      (count_o),
  .done_o       (done_o),
  .unlock_o     (unlock_o),
  .status_low_o (status_low_o)
);

// File: tb/tb_ifc_counter_top.sv
`timescale 1ns/1ps
module tb_ifc_counter_top;
  localparam int CW    = 6;
  localparam int H     = 4;
  localparam int WAITC = 7 * H;
  localparam int GBASE = 8 * H;
  localparam int STR   = 3 * H;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] gate_sel_i = 2'b00;
  logic if_i = 1'b0;
  logic [1:0] ul_mode_i = 2'b00;
  logic phase_err_i = 1'b0;
  logic [2:0] status_sel_i = 3'b000;
  logic ce_i = 1'b0;
  logic sd_on_i = 1'b0;
  logic stereo_i = 1'b0;
  logic [CW-1:0] count_o;
  logic done_o, unlock_o, status_low_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ifc_counter_top #(.CNT_W(CW), .HALF_MS_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gate_sel_i(gate_sel_i),
    .if_i(if_i), .ul_mode_i(ul_mode_i), .phase_err_i(phase_err_i),
    .status_sel_i(status_sel_i), .ce_i(ce_i), .sd_on_i(sd_on_i),
    .stereo_i(stereo_i), .count_o(count_o), .done_o(done_o),
    .unlock_o(unlock_o), .status_low_o(status_low_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int h1, h2, h3, phase, left, glen, m_cnt, m_uc, m_u;
  bit live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; phase = 0; left = 0; glen = 0;
      m_cnt = 0; m_uc = 0; m_u = 0;
    end else begin
      bit edge_now;
      edge_now = (h2 == 1) && (h3 == 0);
      h3 = h2; h2 = h1; h1 = int'(if_i);
      if (ul_mode_i == 2'b00) begin m_uc = 0; m_u = 0; end
      else if (ul_mode_i == 2'b01) begin m_uc = 0; m_u = int'(phase_err_i); end
      else if (phase_err_i) begin m_uc = STR; m_u = 1; end
      else if (m_uc > 0) begin m_uc--; m_u = 1; end
      else m_u = 0;
      if (!start_i) begin phase = 0; left = 0; m_cnt = 0; end
      else if (phase == 0) begin phase = 1; left = WAITC; m_cnt = 0; glen = GBASE << gate_sel_i; end
      else if (phase == 1) begin left--; if (left == 0) begin phase = 2; left = glen; end end
      else if (phase == 2) begin
        if (edge_now && m_cnt < MAXC) m_cnt++;
        left--;
        if (left == 0) phase = 3;
      end
    end
  end

  function automatic int exp_status();
    if (ce_i) return 0;
    case (status_sel_i)
      3'b001: return m_u;
      3'b010: return (phase == 3) ? 1 : 0;
      3'b101: return int'(sd_on_i);
      3'b110: return int'(stereo_i);
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (live) begin
      chk("R5 count", int'(count_o), m_cnt);
      chk("R4 done", int'(done_o), (phase == 3) ? 1 : 0);
      chk("R10 unlock", int'(unlock_o), m_u);
      chk("R7 status", int'(status_low_o), exp_status());
    end
  end

  // IF stimulus: toggles every if_div cycles when nonzero
  int if_div = 0;
  int if_ph = 0;
  always @(negedge clk) begin
    #2;
    if (if_div > 0) begin
      if_ph++;
      if (if_ph >= if_div) begin if_ph = 0; if_i = ~if_i; end
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_gate(input int sel, input int div, output int n);
    gate_sel_i = sel[1:0];
    if_div = div;
    start_i = 1'b1;
    n = 0;
    while (!done_o && n < 3000) begin
      step();
      n++;
      if (n == 20) chk("R3 no count in wait", int'(count_o), 0);
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    summary_and_end();
  end

  initial begin
    int n, c, hi;
    repeat (4) step();
    rst_n = 1'b1;
    step();
    live = 1;
    // R1
    chk("R1 count", int'(count_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 unlock", int'(unlock_o), 0);
    chk("R1 status", int'(status_low_o), 0);

    // gate 00, end-of-count mode on the line
    status_sel_i = 3'b010;
    run_gate(0, 3, n);
    chk("R4 gate 00 length", n, 1 + WAITC + GBASE);
    chk("R8 low at done", int'(status_low_o), 1);
    c = int'(count_o);
    chk("R5 counted edges", (c > 0) ? 1 : 0, 1);
    repeat (10) step();
    chk("R5 frozen count", int'(count_o), c);
    chk("R5 done held", int'(done_o), 1);
    start_i = 1'b0;
    step();
    chk("R2 cleared count", int'(count_o), 0);
    chk("R2 cleared done", int'(done_o), 0);
    chk("R8 open when idle", int'(status_low_o), 0);

    run_gate(1, 2, n);
    chk("R4 gate 01 length", n, 1 + WAITC + 2 * GBASE);
    start_i = 1'b0;
    step();

    // abort mid-gate
    gate_sel_i = 2'b10;
    if_div = 1;
    start_i = 1'b1;
    repeat (60) step();
    chk("R8 open while gating", int'(status_low_o), 0);
    start_i = 1'b0;
    step();
    chk("R2 abort count", int'(count_o), 0);
    chk("R2 abort done", int'(done_o), 0);
    repeat (3) step();

    run_gate(2, 5, n);
    chk("R4 gate 10 length", n, 1 + WAITC + 4 * GBASE);
    start_i = 1'b0;
    step();

    run_gate(3, 1, n);
    chk("R4 gate 11 length", n, 1 + WAITC + 8 * GBASE);
    chk("R6 saturated", int'(count_o), MAXC);
    if_div = 0;

    // R9
    ce_i = 1'b1; #1;
    chk("R9 eoc forced open", int'(status_low_o), 0);
    status_sel_i = 3'b101; sd_on_i = 1'b1; #1;
    chk("R9 sd forced open", int'(status_low_o), 0);
    ce_i = 1'b0; #1;
    chk("R7 sd low", int'(status_low_o), 1);

    // R7 full select sweep with every source active
    ul_mode_i = 2'b01; phase_err_i = 1'b1; stereo_i = 1'b1;
    step(); step();
    for (int s = 0; s < 8; s++) begin
      status_sel_i = s[2:0]; #1;
      chk("R7 select sweep", int'(status_low_o),
          (s == 1 || s == 2 || s == 5 || s == 6) ? 1 : 0);
    end
    sd_on_i = 1'b0; status_sel_i = 3'b101; #1;
    chk("R7 sd off", int'(status_low_o), 0);
    stereo_i = 1'b0; status_sel_i = 3'b110; #1;
    chk("R7 stereo off", int'(status_low_o), 0);

    // R10
    phase_err_i = 1'b0; step();
    chk("R10 direct follows low", int'(unlock_o), 0);
    phase_err_i = 1'b1; step();
    chk("R10 direct follows high", int'(unlock_o), 1);
    ul_mode_i = 2'b00; step(); step();
    chk("R10 stopped", int'(unlock_o), 0);
    ul_mode_i = 2'b10; phase_err_i = 1'b1; step();
    hi = int'(unlock_o);
    phase_err_i = 1'b0;
    for (int k = 0; k < 30; k++) begin step(); hi += int'(unlock_o); end
    chk("R10 stretch length", hi, STR + 1);
    ul_mode_i = 2'b11; phase_err_i = 1'b1; step();
    chk("R10 mode 11 stretches", int'(unlock_o), 1);
    phase_err_i = 1'b0;
    repeat (5) step();
    chk("R10 still held", int'(unlock_o), 1);

    start_i = 1'b0;
    repeat (3) step();
    summary_and_end();
  end
endmodule